// File: doc/BRIEF.md
# Banked Two-Word Program ROM

This block is a read-only program store for an instruction fetch unit. It keeps its words in two 16-bit banks: one holds the words at even addresses and the other the words at odd addresses. Every fetch returns a 32-bit window made of the word at the program counter and the word after it. This works for any program counter parity and costs one clock. The decoder therefore sees the second word of a two-word instruction at the same time as its first word.

A separate byte-wide read port serves table lookups into program space. It takes a byte address and returns one byte, and it runs independently of fetch and stall. The block also returns the fetch address delayed by one clock, so that this address lines up with the opcode it produced. Neither port has a valid/ready handshake. The fetch port has a single back-pressure rule: while `stall` is high, the opcode output and its internal parity state are frozen. The pipeline above is expected to present the same address again when `stall` falls.

Top module: `prog_rom_banked`

## Requirements
- R1: The contents are fixed. Word `a` (0 to 2047) holds `(a*40503 XOR 0xC3A5)` truncated to 16 bits.
- R2: One edge after `fetch_pc` = p is sampled with `stall` low, `opcode[15:0]` equals word p and `opcode[31:16]` equals word p+1. This holds for both even p and odd p.
- R3: At the top address (p = 2047), the upper half of the window wraps around to word 0.
- R4: While `stall` is sampled high, `opcode` keeps its previous value, even if `fetch_pc` changes to an address of the other parity.
- R5: After a stall, the first edge with `stall` low returns the window for the address presented at that edge.
- R6: `pc_dly` equals the `fetch_pc` sampled at the previous edge, whatever the value of `stall`.
- R7: One edge after `byte_addr` = b is sampled, `byte_data` equals a byte of word b>>1. Bit 1 of `byte_addr` picks the bank (0 even, 1 odd). Bit 0 picks the low byte (0) or the high byte (1). This holds up to b = 4095.
- R8: The byte port keeps producing results while `stall` is high, and its results do not depend on `fetch_pc`.
- R9: While `rst_n` is low, `opcode`, `byte_data` and `pc_dly` read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the output registers |
| stall | input | 1 | Freezes the fetch port while high |
| fetch_pc | input | 11 | Word address of the fetch |
| byte_addr | input | 12 | Byte address of the lookup port |
| opcode | output | 32 | Word at fetch_pc (low half) and at fetch_pc+1 (high half) |
| pc_dly | output | 11 | fetch_pc delayed by one clock |
| byte_data | output | 8 | Byte selected by the previous byte_addr |

## Verification
The hardest case to reach from the ports is a stall during which the fetch address changes parity. If the held parity bit followed the address, the two halves of the frozen window would swap while the bank data stayed still. The stimulus holds `stall` high across several cycles and alternates `fetch_pc` between even and odd values, including the wrap address. It then drops the stall on an address of the opposite parity. Byte lookups run through those same stalled cycles, which shows that the second port is independent of the stall.

// File: rtl/prog_rom_pkg.sv
package prog_rom_pkg;
  // Fixed program image: word a holds (a*40503 ^ 0xC3A5) mod 2^16.
  function automatic logic [15:0] rom_word(input int unsigned a);
    int unsigned v;
    v = (a * 32'd40503) ^ 32'h0000_C3A5;
    return v[15:0];
  endfunction
endpackage

// File: rtl/rom_bank.sv
module rom_bank #(
  parameter int AW      = 10,
  parameter int DW      = 16,
  parameter int BANK_ID = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_en,
  input  logic [AW-1:0] a_addr,
  output logic [DW-1:0] a_data,
  input  logic [AW-1:0] b_addr,
  output logic [DW-1:0] b_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++)
      mem[i] = prog_rom_pkg::rom_word(2 * i + BANK_ID);
  end

  // Fetch side: read enabled only when the pipeline advances
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    a_data <= '0;
    else if (a_en) a_data <= mem[a_addr];
  end

  // Lookup side: free running
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) b_data <= '0;
    else        b_data <= mem[b_addr];
  end
endmodule

// File: rtl/fetch_align.sv
module fetch_align #(
  parameter int AW = 11,
  parameter int DW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            stall,
  input  logic [AW-1:0]   pc,
  output logic [AW-2:0]   even_addr,
  output logic [AW-2:0]   odd_addr,
  input  logic [DW-1:0]   even_q,
  input  logic [DW-1:0]   odd_q,
  output logic [2*DW-1:0] window
);
  localparam int RW = AW - 1;

  logic parity_q;

  // Odd bank always at pc/2; even bank one row further for odd pc
  assign odd_addr  = pc[AW-1:1];
  assign even_addr = pc[AW-1:1] + RW'(pc[0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      parity_q <= 1'b0;
    else if (!stall) parity_q <= pc[0];
  end

  always_comb begin
    if (parity_q) window = {even_q, odd_q};
    else          window = {odd_q, even_q};
  end
endmodule

// File: rtl/byte_lane_sel.sv
module byte_lane_sel #(
  parameter int BAW = 12,
  parameter int DW  = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [BAW-1:0] byte_addr,
  output logic [BAW-3:0] row_addr,
  input  logic [DW-1:0]  even_q,
  input  logic [DW-1:0]  odd_q,
  output logic [7:0]     byte_out
);
  logic [1:0]    lane_q;
  logic [DW-1:0] word_sel;

  assign row_addr = byte_addr[BAW-1:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lane_q <= '0;
    else        lane_q <= byte_addr[1:0];
  end

  assign word_sel = lane_q[1] ? odd_q : even_q;
  assign byte_out = lane_q[0] ? word_sel[15:8] : word_sel[7:0];
endmodule

// File: rtl/prog_rom_banked.sv
module prog_rom_banked #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stall,
  input  logic [AW-1:0] fetch_pc,
  input  logic [AW:0]   byte_addr,
  output logic [31:0]   opcode,
  output logic [AW-1:0] pc_dly,
  output logic [7:0]    byte_data
);
  localparam int DW  = 16;
  localparam int RW  = AW - 1;
  localparam int BAW = AW + 1;

  logic [RW-1:0] row_a [2];
  logic [RW-1:0] row_b;
  logic [DW-1:0] q_a   [2];
  logic [DW-1:0] q_b   [2];

  fetch_align #(.AW(AW), .DW(DW)) u_align (
    .clk(clk), .rst_n(rst_n), .stall(stall), .pc(fetch_pc),
    .even_addr(row_a[0]), .odd_addr(row_a[1]),
    .even_q(q_a[0]), .odd_q(q_a[1]), .window(opcode)
  );

  byte_lane_sel #(.BAW(BAW), .DW(DW)) u_lane (
    .clk(clk), .rst_n(rst_n), .byte_addr(byte_addr), .row_addr(row_b),
    .even_q(q_b[0]), .odd_q(q_b[1]), .byte_out(byte_data)
  );

  for (genvar g = 0; g < 2; g++) begin : g_bank
    rom_bank #(.AW(RW), .DW(DW), .BANK_ID(g)) u_bank (
      .clk(clk), .rst_n(rst_n), .a_en(!stall),
      .a_addr(row_a[g]), .a_data(q_a[g]),
      .b_addr(row_b), .b_data(q_b[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_dly <= '0;
    else        pc_dly <= fetch_pc;
  end
endmodule

// File: rtl/prog_rom_banked_checker.sv
module prog_rom_banked_checker #(
  parameter int AW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          stall,
  input logic [AW-1:0] fetch_pc,
  input logic [AW:0]   byte_addr,
  input logic [31:0]   opcode,
  input logic [AW-1:0] pc_dly,
  input logic [7:0]    byte_data
);
  function automatic logic [15:0] wd(input logic [AW-1:0] a);
    return prog_rom_pkg::rom_word(int'(a));
  endfunction

  function automatic logic [7:0] bt(input logic [AW:0] b);
    logic [15:0] w;
    w = wd(b[AW:1]);
    return b[0] ? w[15:8] : w[7:0];
  endfunction

  // R2 low half follows the sampled address
  p_window_lo_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !stall |=> opcode[15:0] == wd($past(fetch_pc)));
  // R3 high half is the next word, wrapping
  p_window_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !stall |=> opcode[31:16] == wd($past(fetch_pc) + 1'b1));
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(opcode));
  p_pc_delay_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> pc_dly == $past(fetch_pc));
  p_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> byte_data == bt($past(byte_addr)));
  // R9 outputs cleared in reset
  always @(negedge clk) if (!rst_n)
    a_reset_r9: assert (opcode == '0 && byte_data == '0 && pc_dly == '0);
endmodule

bind prog_rom_banked prog_rom_banked_checker #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .stall(stall), .fetch_pc(fetch_pc),
  .byte_addr(byte_addr), .opcode(opcode), .pc_dly(pc_dly),
  .byte_data(byte_data)
);

// File: tb/prog_rom_banked_bench.sv
module prog_rom_banked_bench;
  localparam int PERIOD = 10;

  typedef struct {
    logic [31:0] op;
    logic [10:0] pcd;
    logic [7:0]  by;
    string       op_tag;
    string       by_tag;
  } exp_t;

  logic        clk = 0, rst_n = 0, stall = 0;
  logic [10:0] fetch_pc = '0;
  logic [11:0] byte_addr = '0;
  logic [31:0] opcode;
  logic [10:0] pc_dly;
  logic [7:0]  byte_data;

  int checks = 0, fails = 0;
  exp_t q[$];
  logic [31:0] held_op = '0;

  prog_rom_banked u_prog_rom_banked (
    .clk(clk), .rst_n(rst_n), .stall(stall), .fetch_pc(fetch_pc),
    .byte_addr(byte_addr), .opcode(opcode), .pc_dly(pc_dly),
    .byte_data(byte_data)
  );

  always #(PERIOD/2) clk = ~clk;

  // R1 image, computed independently
  function automatic logic [15:0] w(input int a);
    int unsigned v;
    v = (int'(a % 2048) * 32'd40503) ^ 32'h0000_C3A5;
    return v[15:0];
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input int p, input bit s, input int b,
                       input string ot, input string bt);
    exp_t e;
    logic [15:0] bw;
    @(negedge clk);
    fetch_pc  = 11'(p);
    stall     = s;
    byte_addr = 12'(b);
    if (!s) held_op = {w(p + 1), w(p)};
    bw = w(b >> 1);
    e.op = held_op;
    e.pcd = 11'(p);
    e.by = b[0] ? bw[15:8] : bw[7:0];
    e.op_tag = ot;
    e.by_tag = bt;
    q.push_back(e);
  endtask

  // monitor
  initial forever begin
    @(posedge clk);
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(e.op_tag, opcode, e.op);
      chk("R6", {21'd0, pc_dly}, {21'd0, e.pcd});
      chk(e.by_tag, {24'd0, byte_data}, {24'd0, e.by});
    end
  end

  initial begin
    #(PERIOD * 200000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    fetch_pc = 11'd77; byte_addr = 12'd9;
    repeat (3) @(posedge clk);
    #1;
    chk("R9", opcode, 32'd0);
    chk("R9", {24'd0, byte_data}, 32'd0);
    chk("R9", {21'd0, pc_dly}, 32'd0);
    @(negedge clk); rst_n = 1;
    // R2 even and odd addresses, R7 all four lanes
    drive(0, 0, 0, "R2", "R7");
    drive(1, 0, 1, "R2", "R7");
    drive(2, 0, 2, "R2", "R7");
    drive(3, 0, 3, "R2", "R7");
    drive(100, 0, 4095, "R2", "R7");
    drive(513, 0, 4094, "R2", "R7");
    // R3 wrap and the neighbour below it
    drive(2047, 0, 4093, "R3", "R7");
    drive(2046, 0, 4092, "R3", "R7");
    drive(2047, 0, 1234, "R3", "R7");
    // R4 stall with parity flips; R8 byte port keeps running
    drive(10, 0, 20, "R2", "R7");
    drive(11, 1, 21, "R4", "R8");
    drive(2047, 1, 22, "R4", "R8");
    drive(12, 1, 23, "R4", "R8");
    // R5 resume on opposite parity
    drive(7, 0, 24, "R5", "R7");
    drive(8, 1, 25, "R4", "R8");
    drive(8, 0, 26, "R5", "R7");
    // mixed sweep
    for (int i = 0; i < 200; i++)
      drive((i * 331 + 5) % 2048, (i % 7) == 3, (i * 977 + 1) % 4096,
            ((i % 7) == 3) ? "R4" : "R2", "R8");
    repeat (3) @(posedge clk);
    #2;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule